// File: doc/BRIEF.md
# Multidrop 9-bit Receive Address Filter

This block sits behind the receive shifter of a UART that shares one wire pair with many nodes. Each received character arrives as a data word plus a ninth flag bit carried where the parity bit would be. A flag of 1 marks an address character and a flag of 0 marks a data character. A gate flag, `gate_sm2`, decides which characters reach the host. While the gate is shut, data characters are thrown away, so a node ignores traffic meant for other nodes.

The gate can be opened in two ways. In manual mode, address characters reach the host and the host opens the gate with a write. In automatic mode, hardware compares each address character with a masked own address and with a broadcast address. A hit opens the gate and a miss shuts it again. Accepted characters wait in a one-entry holding stage with a valid/ready handshake, together with their flag.

The block also drives the active-low transceiver direction pin. In RS485 operation it asserts the pin whenever the receive side requests it, with an optional polarity inversion. In RS232 operation the pin simply follows the host's request.

Top module: `mdrop_rx_filter`

## Requirements
- R1: After reset, `gate_sm2` is 1 and `acc_valid` is 0.
- R2: With `cfg_multidrop`=0, every character on `rx_valid` is accepted with its flag unchanged, whatever the value of `gate_sm2`. An accepted character appears on `acc_valid`/`acc_data`/`acc_flag` one clock after the clock in which `rx_valid` was high.
- R3: With `cfg_multidrop`=1 and `gate_sm2`=1, a character whose flag is 0 is discarded and raises no `acc_valid`.
- R4: With `cfg_multidrop`=1 and `gate_sm2`=0, data characters (flag 0) are accepted.
- R5: With `cfg_auto`=0, the following hold:
  - An address character (flag 1) is accepted in multidrop mode and leaves `gate_sm2` unchanged.
  - `gate_clr` clears `gate_sm2` on the next clock.
  - `gate_set` sets `gate_sm2` on the next clock.
  - If both are high, `gate_clr` wins.
- R6: With `cfg_multidrop`=1 and `cfg_auto`=1, an address character that equals `cfg_own_addr` on every bit where `cfg_addr_mask` is 1 has the following effects:
  - It is accepted.
  - It clears `gate_sm2`.
  - Bits where the mask is 0 are don't-care.
- R7: Broadcast: an address character that is 1 on every bit where `cfg_addr_mask` is 1 also counts as a hit in automatic mode. This is the broadcast address formed as own address OR mask.
- R8: With `cfg_multidrop`=1 and `cfg_auto`=1, an address character that hits neither address is discarded and sets `gate_sm2`.
- R9: With `cfg_multidrop`=0, `cfg_auto` has no effect and received characters never change `gate_sm2`.
- R10: A host write (`gate_clr` or `gate_set`) in the same clock as a hardware gate update takes priority over the hardware update.
- R11: While `acc_valid`=1 and `acc_ready`=0:
  - `acc_data` and `acc_flag` hold steady.
  - A newly accepted character is dropped.
  - `acc_valid` falls one clock after a ready handshake unless a new character is accepted in that clock.
- R12: The direction pin `rts_n` is combinational and follows these rules:
  - With `cfg_rs485`=0, `rts_n` = NOT `host_rts`.
  - With `cfg_rs485`=1 and `cfg_dir_inv`=0, `rts_n` = NOT `rx_active`.
  - With `cfg_rs485`=1 and `cfg_dir_inv`=1, `rts_n` = `rx_active`.
  - `cfg_dir_inv` is ignored in RS232 operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_multidrop | input | 1 | 1 = 9-bit multidrop mode |
| cfg_auto | input | 1 | 1 = hardware opens/shuts the gate on address match |
| cfg_rs485 | input | 1 | 1 = RS485 direction control |
| cfg_dir_inv | input | 1 | Invert direction pin polarity in RS485 operation |
| cfg_own_addr | input | DATA_W | Own slave address |
| cfg_addr_mask | input | DATA_W | Address compare enable mask |
| gate_clr | input | 1 | Host write clearing the gate flag |
| gate_set | input | 1 | Host write setting the gate flag |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | DATA_W | Received data bits |
| rx_flag | input | 1 | Ninth (address/data) bit |
| rx_active | input | 1 | Receive side requests the line |
| host_rts | input | 1 | Host direction request for RS232 operation |
| acc_valid | output | 1 | Accepted character available |
| acc_ready | input | 1 | Host takes the accepted character |
| acc_data | output | DATA_W | Accepted data bits |
| acc_flag | output | 1 | Accepted ninth bit |
| gate_sm2 | output | 1 | Gate flag, 1 = data characters blocked |
| rts_n | output | 1 | Active-low direction pin |

## Verification
The bench uses the default parameters: DATA_W of 8, the automatic-address variant built in, and the combinational direction path. Together these put every gate transition within reach: host-only, hardware-only, and both in the same clock. The 8-bit width makes an exhaustive feel for the masked compare cheap to approach with random addresses. It also lets directed mask values such as all-zero and all-one hit the own-address and broadcast paths on purpose. Because the direction path is combinational, the pin can be checked in the same cycle its inputs change.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
   // Outcome of qualifying one received character
   typedef enum logic [1:0] {
      DEC_DROP      = 2'd0,
      DEC_PASS      = 2'd1,
      DEC_PASS_OPEN = 2'd2,
      DEC_DROP_SHUT = 2'd3
   } decision_e;

   function automatic logic dec_takes(decision_e d);
      return (d == DEC_PASS) || (d == DEC_PASS_OPEN);
   endfunction
endpackage

// File: rtl/mdrop_addr_match.sv
module mdrop_addr_match #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] addr,
   input  logic [DATA_W-1:0] own,
   input  logic [DATA_W-1:0] mask,
   output logic              hit
);
   logic [DATA_W-1:0] own_ok;
   logic [DATA_W-1:0] bc_ok;
   logic [DATA_W-1:0] bcast;

   assign bcast = own | mask;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign own_ok[b] = ~mask[b] | (addr[b] == own[b]);
      assign bc_ok[b]  = ~mask[b] | (addr[b] == bcast[b]);
   end

   assign hit = (&own_ok) | (&bc_ok);
endmodule

// File: rtl/mdrop_gate.sv
module mdrop_gate
   import mdrop_pkg::*;
#(
   parameter bit AUTO_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_multidrop,
   input  logic cfg_auto,
   input  logic gate_clr,
   input  logic gate_set,
   input  logic rx_valid,
   input  logic rx_flag,
   input  logic addr_hit,
   output logic take,
   output logic sm2_q
);
   logic      auto_eff;
   decision_e dec;
   logic      sm2_d;

   if (AUTO_EN) begin : g_auto
      assign auto_eff = cfg_auto & cfg_multidrop;
   end else begin : g_manual
      assign auto_eff = 1'b0;
   end

   always_comb begin
      dec = DEC_DROP;
      if (rx_valid) begin
         if (!cfg_multidrop) begin
            dec = DEC_PASS;
         end else if (rx_flag) begin
            if (auto_eff) dec = addr_hit ? DEC_PASS_OPEN : DEC_DROP_SHUT;
            else          dec = DEC_PASS;
         end else begin
            dec = sm2_q ? DEC_DROP : DEC_PASS;
         end
      end
   end

   assign take = dec_takes(dec);

   always_comb begin
      sm2_d = sm2_q;
      if (gate_clr)                   sm2_d = 1'b0;
      else if (gate_set)              sm2_d = 1'b1;
      else if (dec == DEC_PASS_OPEN)  sm2_d = 1'b0;
      else if (dec == DEC_DROP_SHUT)  sm2_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sm2_q <= 1'b1;
      else        sm2_q <= sm2_d;
   end

   // R5
   host_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_clr |=> !sm2_q);

   // R6
   auto_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (AUTO_EN && cfg_multidrop && cfg_auto && rx_valid && rx_flag && addr_hit
       && !gate_clr && !gate_set) |=> !sm2_q);

   // R8
   auto_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (AUTO_EN && cfg_multidrop && cfg_auto && rx_valid && rx_flag && !addr_hit
       && !gate_clr && !gate_set) |=> sm2_q);

   // R9
   normal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_multidrop && !gate_clr && !gate_set) |=> $stable(sm2_q));
endmodule

// File: rtl/mdrop_hold.sv
module mdrop_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_flag,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_flag
);
   logic free;
   assign free = ~out_valid | out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_flag  <= 1'b0;
      end else if (free) begin
         out_valid <= take;
         if (take) begin
            out_data <= in_data;
            out_flag <= in_flag;
         end
      end
   end

   // R11
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_flag)));
endmodule

// File: rtl/mdrop_dir.sv
module mdrop_dir #(
   parameter bit DIR_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_rs485,
   input  logic cfg_dir_inv,
   input  logic rx_active,
   input  logic host_rts,
   output logic rts_n
);
   logic want;
   logic pin_d;

   assign want  = cfg_rs485 ? rx_active : host_rts;
   assign pin_d = (cfg_rs485 & cfg_dir_inv) ? want : ~want;

   if (DIR_REG) begin : g_reg
      logic pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_q <= 1'b1;
         else        pin_q <= pin_d;
      end
      assign rts_n = pin_q;
   end else begin : g_comb
      assign rts_n = pin_d;
   end
endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter #(
   parameter int DATA_W  = 8,
   parameter bit AUTO_EN = 1'b1,
   parameter bit DIR_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_multidrop,
   input  logic              cfg_auto,
   input  logic              cfg_rs485,
   input  logic              cfg_dir_inv,
   input  logic [DATA_W-1:0] cfg_own_addr,
   input  logic [DATA_W-1:0] cfg_addr_mask,
   input  logic              gate_clr,
   input  logic              gate_set,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_flag,
   input  logic              rx_active,
   input  logic              host_rts,
   output logic              acc_valid,
   input  logic              acc_ready,
   output logic [DATA_W-1:0] acc_data,
   output logic              acc_flag,
   output logic              gate_sm2,
   output logic              rts_n
);
   if (DATA_W < 2 || DATA_W > 32) begin : g_bad_width
      $error("mdrop_rx_filter: DATA_W must lie in 2..32");
   end

   logic hit;
   logic take;

   mdrop_addr_match #(.DATA_W(DATA_W)) u_match (
      .addr (rx_data),
      .own  (cfg_own_addr),
      .mask (cfg_addr_mask),
      .hit  (hit)
   );

   mdrop_gate #(.AUTO_EN(AUTO_EN)) u_gate (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_multidrop (cfg_multidrop),
      .cfg_auto      (cfg_auto),
      .gate_clr      (gate_clr),
      .gate_set      (gate_set),
      .rx_valid      (rx_valid),
      .rx_flag       (rx_flag),
      .addr_hit      (hit),
      .take          (take),
      .sm2_q         (gate_sm2)
   );

   mdrop_hold #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .in_data   (rx_data),
      .in_flag   (rx_flag),
      .out_ready (acc_ready),
      .out_valid (acc_valid),
      .out_data  (acc_data),
      .out_flag  (acc_flag)
   );

   mdrop_dir #(.DIR_REG(DIR_REG)) u_dir (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_rs485   (cfg_rs485),
      .cfg_dir_inv (cfg_dir_inv),
      .rx_active   (rx_active),
      .host_rts    (host_rts),
      .rts_n       (rts_n)
   );

   // R3
   gated_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!acc_valid || acc_ready) && cfg_multidrop && gate_sm2 && rx_valid && !rx_flag)
      |=> !acc_valid);

   // R2
   normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!acc_valid || acc_ready) && !cfg_multidrop && rx_valid)
      |=> (acc_valid && acc_flag == $past(rx_flag)));
endmodule

// File: tb/mdrop_rx_filter_tb.sv
module mdrop_rx_filter_tb;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_multidrop = 0, cfg_auto = 0, cfg_rs485 = 0, cfg_dir_inv = 0;
   logic [DW-1:0] cfg_own_addr = '0, cfg_addr_mask = '0;
   logic gate_clr = 0, gate_set = 0, rx_valid = 0, rx_flag = 0;
   logic [DW-1:0] rx_data = '0;
   logic rx_active = 0, host_rts = 0, acc_ready = 0;
   logic acc_valid, acc_flag, gate_sm2, rts_n;
   logic [DW-1:0] acc_data;

   always #2 clk = ~clk;

   mdrop_rx_filter u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_multidrop(cfg_multidrop), .cfg_auto(cfg_auto),
      .cfg_rs485(cfg_rs485), .cfg_dir_inv(cfg_dir_inv),
      .cfg_own_addr(cfg_own_addr), .cfg_addr_mask(cfg_addr_mask),
      .gate_clr(gate_clr), .gate_set(gate_set),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_flag(rx_flag),
      .rx_active(rx_active), .host_rts(host_rts),
      .acc_valid(acc_valid), .acc_ready(acc_ready),
      .acc_data(acc_data), .acc_flag(acc_flag),
      .gate_sm2(gate_sm2), .rts_n(rts_n)
   );

   int n_vec = 0, n_bad = 0;
   logic m_sm2, m_v, m_f;
   logic [DW-1:0] m_d;

   task automatic check(string req, string what, int act, int exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic ref_hit(logic [DW-1:0] a, logic [DW-1:0] own, logic [DW-1:0] msk);
      return (((a ^ own) & msk) == '0) || (((a ^ (own | msk)) & msk) == '0);
   endfunction

   function automatic logic ref_rts(logic r485, logic inv, logic act, logic hr);
      if (!r485) return ~hr;
      return inv ? act : ~act;
   endfunction

   // apply current inputs for one clock and compare with the model
   task automatic step(string req);
      logic take, hit, md_auto;
      #1;
      check(req, "rts_n", rts_n, ref_rts(cfg_rs485, cfg_dir_inv, rx_active, host_rts));
      hit = ref_hit(rx_data, cfg_own_addr, cfg_addr_mask);
      md_auto = cfg_multidrop & cfg_auto;
      take = 1'b0;
      if (rx_valid) begin
         if (!cfg_multidrop)  take = 1'b1;
         else if (rx_flag)    take = md_auto ? hit : 1'b1;
         else                 take = ~m_sm2;
      end
      if (!m_v || acc_ready) begin
         m_v = take;
         if (take) begin m_d = rx_data; m_f = rx_flag; end
      end
      if (gate_clr)                               m_sm2 = 1'b0;
      else if (gate_set)                          m_sm2 = 1'b1;
      else if (md_auto && rx_valid && rx_flag)    m_sm2 = ~hit;
      @(posedge clk);
      @(negedge clk);
      check(req, "gate_sm2", gate_sm2, m_sm2);
      check(req, "acc_valid", acc_valid, m_v);
      if (m_v) begin
         check(req, "acc_data", acc_data, m_d);
         check(req, "acc_flag", acc_flag, m_f);
      end
      gate_clr = 0; gate_set = 0; rx_valid = 0;
   endtask

   task automatic send(logic [DW-1:0] d, logic f, logic rdy, string req);
      rx_valid = 1; rx_data = d; rx_flag = f; acc_ready = rdy;
      step(req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      int unused;
      unused = $urandom(32'h5EED_1234);
      m_sm2 = 1; m_v = 0; m_d = '0; m_f = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "gate_sm2", gate_sm2, 1);
      check("R1", "acc_valid", acc_valid, 0);
      rst_n = 1;
      @(negedge clk);

      // R2: normal mode passes everything, flag untouched
      send(8'h3C, 1'b0, 1'b1, "R2");
      send(8'hA5, 1'b1, 1'b1, "R2");
      // R9: auto set but not multidrop; sm2 untouched by characters
      cfg_auto = 1; cfg_own_addr = 8'h12; cfg_addr_mask = 8'hFF;
      send(8'h12, 1'b1, 1'b1, "R9");
      send(8'h77, 1'b1, 1'b1, "R9");
      check("R9", "gate_sm2 kept", gate_sm2, 1);

      // R3: multidrop, gate shut, data discarded
      cfg_multidrop = 1; cfg_auto = 0; acc_ready = 1;
      send(8'h55, 1'b0, 1'b1, "R3");
      check("R3", "acc_valid after data", acc_valid, 0);
      // R5: manual mode address passes, gate unchanged
      send(8'h99, 1'b1, 1'b1, "R5");
      check("R5", "sm2 unchanged", gate_sm2, 1);
      gate_clr = 1; step("R5");
      check("R5", "sm2 cleared", gate_sm2, 0);
      // R4: gate open, data accepted
      send(8'h0F, 1'b0, 1'b1, "R4");
      gate_set = 1; step("R5");
      gate_set = 1; gate_clr = 1; step("R5");
      check("R5", "clr wins", gate_sm2, 0);

      // R6: auto mode masked own-address hit
      cfg_auto = 1; cfg_own_addr = 8'h12; cfg_addr_mask = 8'h0F;
      gate_set = 1; step("R6");
      send(8'hF2, 1'b1, 1'b1, "R6");
      check("R6", "masked hit opens", gate_sm2, 0);
      send(8'h44, 1'b0, 1'b1, "R4");
      // R8: mismatch shuts and discards
      send(8'h13, 1'b1, 1'b1, "R8");
      check("R8", "miss shuts", gate_sm2, 1);
      send(8'h44, 1'b0, 1'b1, "R8");
      // R7: broadcast (ones on all mask bits)
      send(8'h6F, 1'b1, 1'b1, "R7");
      check("R7", "broadcast opens", gate_sm2, 0);
      // R10: host write beats hardware update
      rx_valid = 1; rx_data = 8'h00; rx_flag = 1; gate_clr = 1; step("R10");
      check("R10", "clr beats miss", gate_sm2, 0);
      gate_set = 1; step("R6");
      rx_valid = 1; rx_data = 8'h12; rx_flag = 1; gate_set = 1; step("R10");
      check("R10", "set beats hit", gate_sm2, 1);

      // R11: hold while not ready, new character dropped
      gate_clr = 1; step("R11");
      send(8'hC1, 1'b0, 1'b0, "R11");
      send(8'hC2, 1'b0, 1'b0, "R11");
      check("R11", "held data", acc_data, 8'hC1);
      acc_ready = 1; step("R11");
      check("R11", "valid falls", acc_valid, 0);

      // R12: direction pin in all modes
      for (int k = 0; k < 16; k++) begin
         {cfg_rs485, cfg_dir_inv, rx_active, host_rts} = 4'(k);
         step("R12");
      end

      // random phase
      for (int i = 0; i < 4000; i++) begin
         if ((i % 97) == 0) begin
            cfg_multidrop = 1'($urandom);
            cfg_auto      = 1'($urandom);
            cfg_own_addr  = 8'($urandom);
            cfg_addr_mask = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
         end
         rx_valid  = ($urandom % 4) != 0;
         rx_flag   = 1'($urandom);
         rx_data   = ($urandom % 3 == 0) ? cfg_own_addr : 8'($urandom);
         acc_ready = ($urandom % 4) != 0;
         gate_clr  = ($urandom % 16) == 0;
         gate_set  = ($urandom % 16) == 0;
         {cfg_rs485, cfg_dir_inv, rx_active, host_rts} = 4'($urandom);
         step(cfg_multidrop ? (cfg_auto ? "R6" : "R5") : "R2");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule